// File: doc/BRIEF.md
# EEPROM Request Controller

This block is the front end of a two-wire EEPROM controller. A user issues a one-cycle write request or read request together with a 16-bit memory address and an 8-bit write value. When the controller is idle it accepts the request and copies the address and data into holding registers. It then starts the matching bus engine (write engine or read engine) with a single-cycle start flag, and it keeps its busy output high until that engine returns its done pulse.

The two engines share one clock pin on the bus. The controller passes the clock output of the active engine to that pin and holds the pin high when no transfer is running. The engines produce the bit timing and the EEPROM framing from the held operands. Those engines sit outside this block.

Top module: `eeprom_req_ctrl`

## Requirements
- R1: After a synchronous active-low reset, `busy` is 0, `wr_start` and `rd_start` are 0, `addr_q` and `wdata_q` are 0, and `scl_out` is 1.
- R2: When idle, a `wr_req` pulse sampled at a clock edge makes `wr_start` 1 and `busy` 1 in the following cycle.
- R3: When idle, a `rd_req` pulse alone sampled at a clock edge makes `rd_start` 1 and `busy` 1 in the following cycle.
- R4: If `wr_req` and `rd_req` are both 1 at the same edge while idle, the write is accepted and no read is started.
- R5: Each start flag is 1 for exactly one cycle. It rises only on entry to its operation.
- R6: On acceptance of either request, `addr` and `wr_data` are copied into `addr_q` and `wdata_q`. These registers hold their values until the next accepted request.
- R7: `busy` stays 1 until the done pulse of the active engine. The done pulse of the other engine has no effect.
- R8: Requests that arrive while `busy` is 1 are dropped. No start flag rises and the held operands do not change.
- R9: `scl_out` follows `scl_from_wr` during a write and `scl_from_rd` during a read, and it is 1 while idle.
- R10: The cycle after a done pulse the controller is idle, and a request in that cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_req | input | 1 | Write request pulse |
| rd_req | input | 1 | Read request pulse |
| addr | input | 16 | Memory address for the request |
| wr_data | input | 8 | Byte to write |
| wr_done | input | 1 | Completion pulse from the write engine |
| rd_done | input | 1 | Completion pulse from the read engine |
| scl_from_wr | input | 1 | Bus clock produced by the write engine |
| scl_from_rd | input | 1 | Bus clock produced by the read engine |
| wr_start | output | 1 | One-cycle start flag to the write engine |
| rd_start | output | 1 | One-cycle start flag to the read engine |
| addr_q | output | 16 | Held address used by the engines |
| wdata_q | output | 8 | Held write byte used by the write engine |
| busy | output | 1 | High while an operation is in progress |
| scl_out | output | 1 | Shared bus clock pin |

## Verification
The bench targets four corner cases:

- **Simultaneous requests.** A design that ignored the write priority would start the read engine, or both engines, when the two requests arrive together.
- **Request during a transfer.** If a request arrives mid-transfer and the controller does not drop it, it either pulses a start flag while busy or overwrites the held address under a running engine.
- **Done pulse from the idle engine.** A done pulse from the engine that is not active would release `busy` early if the controller did not match done to the active operation.
- **Clock routing.** Both engine clocks are toggled separately, so a swapped or stuck clock selection shows up on `scl_out`. A request made in the cycle straight after a done pulse shows whether the return to idle costs an extra cycle.

// File: rtl/eeprom_req_pkg.sv
// Shared types for the EEPROM request controller.
package eeprom_req_pkg;
    // Operation states; IDLE must stay all-zero for reset.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_READ  = 2'd2
    } op_state_t;
endpackage

// File: rtl/req_arbiter.sv
// Request arbiter: accepts a write or read request only when idle, with
// write priority, tracks the active operation and emits one-cycle start
// flags. Assumes engines never report done in the cycle they are started.
module req_arbiter
    import eeprom_req_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_req,
    input  logic      rd_req,
    input  logic      wr_done,
    input  logic      rd_done,
    output op_state_t state,
    output logic      capture,
    output logic      wr_start,
    output logic      rd_start
);
    op_state_t state_nx;
    logic      take_wr;
    logic      take_rd;

    // Acceptance decode: only from idle, write wins a tie.
    always_comb begin
        take_wr = (state == ST_IDLE) && wr_req;
        take_rd = (state == ST_IDLE) && rd_req && !wr_req;
        capture = take_wr || take_rd;
    end

    // Next-state logic: leave an operation only on its own engine's done.
    always_comb begin
        state_nx = state;
        case (state)
            ST_IDLE:  if (take_wr) state_nx = ST_WRITE;
                      else if (take_rd) state_nx = ST_READ;
            ST_WRITE: if (wr_done) state_nx = ST_IDLE;
            ST_READ:  if (rd_done) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Start flags: registered, high only in the first cycle of an operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_start <= 1'b0;
            rd_start <= 1'b0;
        end else begin
            wr_start <= take_wr;
            rd_start <= take_rd;
        end
    end

    assert_start_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_start || rd_start) |=> (!wr_start && !rd_start));
    assert_write_priority_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && wr_req && rd_req) |=> (wr_start && !rd_start));
    assert_drop_when_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> (!wr_start && !rd_start));
    assert_hold_until_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WRITE && !wr_done) |=> (state == ST_WRITE));
    assert_one_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_start, rd_start}));
endmodule

// File: rtl/operand_latch.sv
// Operand holding registers: copy address and write byte when a request is
// accepted and keep them steady for the engines for the whole operation.
module operand_latch #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic              busy,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] data_in,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] data_q
);
    // Capture both operands on any accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
        end else if (capture) begin
            addr_q <= addr_in;
            data_q <= data_in;
        end
    end

    assert_operands_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(addr_q) && $stable(data_q)));
endmodule

// File: rtl/scl_mux.sv
// Bus clock selector: routes the active engine's clock to the shared pin,
// parks the pin high while idle.
module scl_mux
    import eeprom_req_pkg::*;
(
    input  op_state_t state,
    input  logic      scl_wr,
    input  logic      scl_rd,
    output logic      scl
);
    // Select by active operation.
    always_comb begin
        case (state)
            ST_WRITE: scl = scl_wr;
            ST_READ:  scl = scl_rd;
            default:  scl = 1'b1;
        endcase
    end
endmodule

// File: rtl/eeprom_req_ctrl.sv
// EEPROM request controller top: arbitrates write/read requests onto one
// two-wire bus, holds operands, starts engines and muxes the bus clock.
// Assumes request inputs are single-cycle pulses synchronous to clk.
module eeprom_req_ctrl
    import eeprom_req_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_req,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_done,
    input  logic              rd_done,
    input  logic              scl_from_wr,
    input  logic              scl_from_rd,
    output logic              wr_start,
    output logic              rd_start,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic              busy,
    output logic              scl_out
);
    op_state_t state;
    logic      capture;

    req_arbiter u_arb (
        .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .rd_req(rd_req),
        .wr_done(wr_done), .rd_done(rd_done), .state(state),
        .capture(capture), .wr_start(wr_start), .rd_start(rd_start)
    );

    operand_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_latch (
        .clk(clk), .rst_n(rst_n), .capture(capture), .busy(busy),
        .addr_in(addr), .data_in(wr_data), .addr_q(addr_q), .data_q(wdata_q)
    );

    scl_mux u_scl (
        .state(state), .scl_wr(scl_from_wr), .scl_rd(scl_from_rd), .scl(scl_out)
    );

    // Busy flag: any operation in progress.
    always_comb busy = (state != ST_IDLE);

    assert_scl_idle_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> scl_out);
    assert_start_sets_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_start || rd_start) |-> busy);
endmodule

// File: tb/test_eeprom_req_ctrl.sv
`timescale 1ns/1ps
module test_eeprom_req_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_req = 0, rd_req = 0, wr_done = 0, rd_done = 0;
    logic        scl_from_wr = 1, scl_from_rd = 1;
    logic [15:0] addr = '0;
    logic [7:0]  wr_data = '0;
    logic        wr_start, rd_start, busy, scl_out;
    logic [15:0] addr_q;
    logic [7:0]  wdata_q;
    int          n_chk = 0, n_fail = 0;
    logic [15:0] exp_addr = '0;
    logic [7:0]  exp_data = '0;

    always #5 clk = ~clk;

    eeprom_req_ctrl i_eeprom_req_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .rd_req(rd_req),
        .addr(addr), .wr_data(wr_data), .wr_done(wr_done), .rd_done(rd_done),
        .scl_from_wr(scl_from_wr), .scl_from_rd(scl_from_rd),
        .wr_start(wr_start), .rd_start(rd_start), .addr_q(addr_q),
        .wdata_q(wdata_q), .busy(busy), .scl_out(scl_out)
    );

    // Vector: {wr_req, rd_req, addr, data, expected op: 0 none, 1 write, 2 read}
    localparam logic [27:0] VEC [6] = '{
        {2'b10, 16'h1234, 8'hA5, 2'd1},
        {2'b01, 16'hBEEF, 8'h3C, 2'd2},
        {2'b11, 16'h0001, 8'hFF, 2'd1},
        {2'b00, 16'h5555, 8'h11, 2'd0},
        {2'b01, 16'hFFFF, 8'h00, 2'd2},
        {2'b10, 16'h0000, 8'h7E, 2'd1}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    initial begin
        #(200000 * 10);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 busy", busy, 0);
        chk("R1 starts", {wr_start, rd_start}, 0);
        chk("R1 addr_q", addr_q, 0);
        chk("R1 wdata_q", wdata_q, 0);
        chk("R1 scl", scl_out, 1);

        // Table walk
        for (int i = 0; i < 6; i++) begin
            logic [1:0] op;
            op = VEC[i][1:0];
            {wr_req, rd_req} = VEC[i][27:26];
            addr = VEC[i][25:10];
            wr_data = VEC[i][9:2];
            @(negedge clk);
            wr_req = 0; rd_req = 0;
            if (op != 0) begin exp_addr = VEC[i][25:10]; exp_data = VEC[i][9:2]; end
            chk("R2 wr_start", wr_start, op == 1);
            chk("R3 rd_start / R4 priority", rd_start, op == 2);
            chk("R2 R3 busy", busy, op != 0);
            chk("R6 addr_q", addr_q, exp_addr);
            chk("R6 wdata_q", wdata_q, exp_data);
            if (op != 0) begin
                scl_from_wr = 0; scl_from_rd = 1; #1;
                chk("R9 scl route a", scl_out, op == 2);
                scl_from_wr = 1; scl_from_rd = 0; #1;
                chk("R9 scl route b", scl_out, op == 1);
                scl_from_wr = 1; scl_from_rd = 1;
                @(negedge clk);
                chk("R5 start one cycle", {wr_start, rd_start}, 0);
                if (op == 1) wr_done = 1; else rd_done = 1;
                @(negedge clk);
                wr_done = 0; rd_done = 0;
                chk("R7 busy released", busy, 0);
                chk("R9 scl idle", scl_out, 1);
            end
        end

        // R8 drop while busy, R7 foreign done ignored
        wr_req = 1; addr = 16'hA0A0; wr_data = 8'h5A;
        @(negedge clk);
        wr_req = 0; exp_addr = 16'hA0A0; exp_data = 8'h5A;
        rd_req = 1; addr = 16'h0F0F; wr_data = 8'hC3;
        @(negedge clk);
        rd_req = 0;
        chk("R8 no start while busy", {wr_start, rd_start}, 0);
        chk("R8 addr_q held", addr_q, exp_addr);
        chk("R8 wdata_q held", wdata_q, exp_data);
        wr_req = 1;
        @(negedge clk);
        wr_req = 0;
        chk("R8 wr dropped", wr_start, 0);
        rd_done = 1;
        @(negedge clk);
        rd_done = 0;
        chk("R7 foreign done ignored", busy, 1);
        scl_from_wr = 0; #1;
        chk("R9 still write clock", scl_out, 0);
        scl_from_wr = 1;
        wr_done = 1;
        @(negedge clk);
        wr_done = 0;
        chk("R7 own done ends", busy, 0);
        // R10 request immediately after done
        rd_req = 1; addr = 16'h7777;
        @(negedge clk);
        rd_req = 0;
        chk("R10 back-to-back accept", rd_start, 1);
        chk("R10 addr", addr_q, 16'h7777);
        // R1 reset mid-operation
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        chk("R1 reset clears busy", busy, 0);
        chk("R1 reset clears addr", addr_q, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule